// File: doc/BRIEF.md
# MDIO Management Slave (Clause 22 Frames)

This block is the PHY-side end of a two-wire serial management bus. It runs entirely on the management clock MDC, which the station drives and may stop while the bus is idle. It samples the shared MDIO line on every rising edge of MDC and looks for frames addressed to its own 5-bit PHY address. That address is taken from strap inputs on the first MDC edge after reset.

A write frame stores a 16-bit word in one of 32 registers. A read frame returns a register's contents on the line. The slave leaves the line alone for the first turnaround bit, drives a zero on the second, and then shifts out sixteen data bits, most significant first. The line itself is modelled as an output value plus an output enable. The pull-up sits outside the block.

A local port gives the rest of the chip a combinational read of any register, plus a one-cycle strobe that reports each write accepted from the bus.

Top module: `mgmt_serial_slave`

## Requirements
- R1: While reset is asserted and after it is released, mdio_oe and rf_we are 0 and every one of the 32 registers reads 0x0000.
- R2: The PHY address is copied from phy_addr_strap on the first MDC rising edge after the synchronized reset release. Later changes of phy_addr_strap do not change which frames are accepted.
- R3: The line value at the first MDC rising edge after the synchronized reset release is not decoded. Reset release takes two MDC edges to synchronize, so this is the third rising edge after rst_n goes high.
- R4: A frame starts with a 0 followed by a 1 (start pattern 01). Any number of ones before it, including none, is accepted as preamble.
- R5: After the start, the frame carries, in this order and MSB first: a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits. Opcode 01 with a matching PHY address writes the data to the addressed register. rf_we is then high for exactly one cycle, with rf_waddr and rf_wdata showing the target.
- R6: Opcode 10 with a matching PHY address is a read. mdio_oe stays 0 during the first turnaround bit, the slave drives 0 during the second, and then it drives the 16 register bits MSB first, one per MDC cycle.
- R7: The slave releases MDIO (mdio_oe = 0) straight after the last read data bit, so its drive lasts exactly 17 bit times.
- R8: A frame whose PHY address does not match is ignored: no drive and no write. Decoding resumes after its 32nd bit slot, counted from the first start bit, and the next frame is handled normally.
- R9: A frame with opcode 00 or 11 is ignored in the same way as in R8, even when its PHY address matches.
- R10: rf_rdata always shows the register selected by rf_addr, combinationally. It holds steady unless rf_addr changes or a write was just accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station; may stop when idle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | PHY address strap, captured once after reset |
| mdio_i | input | 1 | Resolved MDIO line level |
| mdio_o | output | 1 | Value the slave drives onto MDIO |
| mdio_oe | output | 1 | Output enable for MDIO |
| rf_addr | input | 5 | Local register read address |
| rf_rdata | output | 16 | Local register read data |
| rf_we | output | 1 | One-cycle strobe for a write accepted from the bus |
| rf_waddr | output | 5 | Register address of the accepted write |
| rf_wdata | output | 16 | Data of the accepted write |

## Verification
Writes are sent both with a long preamble and with none, which shows that the start detector does not depend on preamble. Reads of the lowest register, the highest register and a mixed pattern separate a correct MSB-first shift from a reversed or offset one, and the turnaround slots are observed one at a time. Frames with a foreign address, with opcodes 00 and 11, and with a strap changed after reset must leave the registers and the line untouched, and each is followed by a good frame to show that framing recovers. A start pattern placed on the cycle just after reset shows whether that cycle is really skipped, because decoding it would produce a valid write.

// File: rtl/mss_pkg.sv
package mss_pkg;

  typedef enum logic [1:0] {
    ST_SKIP  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_START = 2'd2,
    ST_BODY  = 2'd3
  } mss_state_e;

  localparam int OP_W   = 2;
  localparam int TA_W   = 2;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mss_rst_sync.sv
module mss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mss_regfile.sv
module mss_regfile #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] ent_w [NREG];

  generate
    for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
      logic          en;
      logic [DW-1:0] val_q;

      assign en = we && (waddr == AW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (en) begin
          val_q <= wdata;
        end
      end

      assign ent_w[gi] = val_q;
    end
  endgenerate

  assign rd_a = ent_w[ra_a];
  assign rd_b = ent_w[ra_b];

endmodule

// File: rtl/mss_tx_drive.sv
module mss_tx_drive #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lead_zero,
  input  logic          shift,
  input  logic          stop,
  output logic          mdio_o,
  output logic          mdio_oe
);

  logic [DW-1:0] sh_q, sh_d;
  logic          o_q, o_d;
  logic          oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    o_d  = o_q;
    oe_d = oe_q;
    if (load) begin
      sh_d = load_data;
    end
    if (lead_zero) begin
      oe_d = 1'b1;
      o_d  = 1'b0;
    end
    if (shift) begin
      o_d  = sh_q[DW-1];
      sh_d = {sh_q[DW-2:0], 1'b0};
    end
    if (stop) begin
      oe_d = 1'b0;
      o_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      o_q  <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      o_q  <= o_d;
      oe_q <= oe_d;
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

endmodule

// File: rtl/mss_frame_fsm.sv
module mss_frame_fsm
  import mss_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] strap,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_zero,
  output logic              tx_shift,
  output logic              tx_stop,
  output logic              wr_req,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int HDR_W    = OP_W + PHY_AW + REG_AW;
  localparam int BODY_LEN = HDR_W + TA_W + DATA_W;
  localparam int POS_W    = $clog2(BODY_LEN);
  localparam logic [POS_W-1:0] P_HDR_LAST = POS_W'(HDR_W - 1);
  localparam logic [POS_W-1:0] P_TA1      = POS_W'(HDR_W);
  localparam logic [POS_W-1:0] P_TA2      = POS_W'(HDR_W + 1);
  localparam logic [POS_W-1:0] P_DAT0     = POS_W'(HDR_W + TA_W);
  localparam logic [POS_W-1:0] P_LAST     = POS_W'(BODY_LEN - 1);

  mss_state_e        state_q, state_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-2:0] dat_q;
  logic [PHY_AW-1:0] my_addr_q;
  logic              rd_hit_q, wr_hit_q;
  logic              wr_req_q;
  logic [REG_AW-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic [HDR_W-1:0]  hdr_nxt;
  logic [OP_W-1:0]   op_now;
  logic [PHY_AW-1:0] phy_now;
  logic              in_body;
  logic              at_hdr_last;
  logic              addr_match;
  logic              rd_now, wr_now;
  logic              hdr_en, dat_en, hit_en, strap_en, wr_fire;

  // header assembled including the bit on the line this cycle
  assign hdr_nxt     = {hdr_q, mdio_i};
  assign op_now      = hdr_nxt[HDR_W-1 -: OP_W];
  assign phy_now     = hdr_nxt[REG_AW +: PHY_AW];
  assign in_body     = (state_q == ST_BODY);
  assign at_hdr_last = in_body && (pos_q == P_HDR_LAST);
  assign addr_match  = (phy_now == my_addr_q);
  assign rd_now      = at_hdr_last && addr_match && (op_now == OP_READ);
  assign wr_now      = at_hdr_last && addr_match && (op_now == OP_WRITE);

  // clock enables
  assign strap_en = (state_q == ST_SKIP);
  assign hdr_en   = in_body && (pos_q <= P_HDR_LAST);
  assign dat_en   = in_body && (pos_q >= P_DAT0) && (pos_q != P_LAST);
  assign hit_en   = at_hdr_last || (state_q == ST_START);
  assign wr_fire  = in_body && (pos_q == P_LAST) && wr_hit_q;

  // next state
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    unique case (state_q)
      ST_SKIP: begin
        state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!mdio_i) begin
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (mdio_i) begin
          state_d = ST_BODY;
          pos_d   = '0;
        end
      end
      ST_BODY: begin
        if (pos_q == P_LAST) begin
          state_d = ST_IDLE;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SKIP;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      my_addr_q <= '0;
    end else if (strap_en) begin
      my_addr_q <= strap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
    end else if (hdr_en) begin
      hdr_q <= hdr_nxt[HDR_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_en) begin
      dat_q <= {dat_q[DATA_W-3:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit_q <= 1'b0;
      wr_hit_q <= 1'b0;
    end else if (hit_en) begin
      rd_hit_q <= rd_now;
      wr_hit_q <= wr_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req_q <= 1'b0;
    end else begin
      wr_req_q <= wr_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (wr_fire) begin
      wr_addr_q <= hdr_q[REG_AW-1:0];
      wr_data_q <= {dat_q, mdio_i};
    end
  end

  // read-back path control
  assign rd_addr  = hdr_nxt[REG_AW-1:0];
  assign tx_load  = rd_now;
  assign tx_data  = rd_data;
  assign tx_zero  = in_body && rd_hit_q && (pos_q == P_TA1);
  assign tx_shift = in_body && rd_hit_q && (pos_q >= P_TA2) && (pos_q != P_LAST);
  assign tx_stop  = in_body && rd_hit_q && (pos_q == P_LAST);

  assign wr_req  = wr_req_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] phy_addr_strap,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [REG_AW-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);

  logic              rst_i_n;
  logic [REG_AW-1:0] fsm_raddr;
  logic [DATA_W-1:0] fsm_rdata;
  logic              tx_load, tx_zero, tx_shift, tx_stop;
  logic [DATA_W-1:0] tx_data;

  mss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (mdc),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mss_frame_fsm #(
    .PHY_AW (PHY_AW),
    .REG_AW (REG_AW),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk      (mdc),
    .rst_n    (rst_i_n),
    .mdio_i   (mdio_i),
    .strap    (phy_addr_strap),
    .rd_addr  (fsm_raddr),
    .rd_data  (fsm_rdata),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .tx_zero  (tx_zero),
    .tx_shift (tx_shift),
    .tx_stop  (tx_stop),
    .wr_req   (rf_we),
    .wr_addr  (rf_waddr),
    .wr_data  (rf_wdata)
  );

  mss_regfile #(
    .AW (REG_AW),
    .DW (DATA_W)
  ) u_regs (
    .clk   (mdc),
    .rst_n (rst_i_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_a  (fsm_raddr),
    .rd_a  (fsm_rdata),
    .ra_b  (rf_addr),
    .rd_b  (rf_rdata)
  );

  mss_tx_drive #(.DW(DATA_W)) u_tx (
    .clk       (mdc),
    .rst_n     (rst_i_n),
    .load      (tx_load),
    .load_data (tx_data),
    .lead_zero (tx_zero),
    .shift     (tx_shift),
    .stop      (tx_stop),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_addr,
  input logic [DATA_W-1:0] rf_rdata
);

  localparam int MAX_RUN = DATA_W + 1;
  localparam int RUN_W   = $clog2(MAX_RUN + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (mdio_oe) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R6: the first driven bit time carries a zero
  p_lead_zero_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R7: a drive run never exceeds turnaround bit plus data bits
  p_drive_len_r7: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (run_q < RUN_W'(MAX_RUN)));

  // R5: write strobe lasts a single cycle
  p_we_single_r5: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R5: a write never overlaps the slave driving the line
  p_we_no_drive_r5: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |-> !mdio_oe);

  // R10: local read data only moves with its address or after a write
  p_rdata_hold_r10: assert property (@(posedge mdc) disable iff (!rst_n)
    ($stable(rf_addr) && !$past(rf_we)) |-> $stable(rf_rdata));

endmodule

bind mgmt_serial_slave mss_checker #(
  .REG_AW (REG_AW),
  .DATA_W (DATA_W)
) u_mss_chk (
  .mdc      (mdc),
  .rst_n    (rst_n),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .rf_we    (rf_we),
  .rf_addr  (rf_addr),
  .rf_rdata (rf_rdata)
);

// File: tb/mgmt_serial_slave_tb_top.sv
`timescale 1ns/1ps
module mgmt_serial_slave_tb_top;

  logic        mdc;
  logic        rst_n;
  logic [4:0]  strap;
  logic        m_oe;
  logic        m_val;
  logic        line;
  logic        mdio_o;
  logic        mdio_oe;
  logic [4:0]  rf_addr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [15:0] rf_wdata;

  int n_chk;
  int n_fail;
  int we_cnt;
  int oe_cnt;
  logic [4:0]  last_wa;
  logic [15:0] last_wd;

  assign line = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

  mgmt_serial_slave dut_i (
    .mdc            (mdc),
    .rst_n          (rst_n),
    .phy_addr_strap (strap),
    .mdio_i         (line),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .rf_addr        (rf_addr),
    .rf_rdata       (rf_rdata),
    .rf_we          (rf_we),
    .rf_waddr       (rf_waddr),
    .rf_wdata       (rf_wdata)
  );

  initial mdc = 1'b0;
  always #4 mdc = ~mdc;

  always @(posedge mdc) begin
    if (rf_we) begin
      we_cnt  <= we_cnt + 1;
      last_wa <= rf_waddr;
      last_wd <= rf_wdata;
    end
    if (mdio_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    m_oe  = 1'b1;
    m_val = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge mdc);
      m_oe = 1'b0;
    end
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 4; i >= 0; i--) bit_out(phy[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
  endtask

  task automatic send_tail(input logic [1:0] ta, input logic [15:0] d);
    for (int i = 1; i >= 0; i--) bit_out(ta[i]);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    idle(4);
  endtask

  task automatic send_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] d);
    send_hdr(pre, op, phy, ra);
    send_tail(2'b10, d);
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] v);
    @(negedge mdc);
    rf_addr = a;
    #1 v = rf_rdata;
  endtask

  // read frame with per-slot observation of the line
  task automatic mdio_read(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] d, output bit ta1_ok, output bit ta2_ok,
                           output bit drv_ok, output bit rel_ok);
    send_hdr(pre, 2'b10, phy, ra);
    @(negedge mdc);
    m_oe = 1'b0;
    #1 ta1_ok = !mdio_oe && line;
    @(negedge mdc);
    #1 ta2_ok = mdio_oe && !line;
    drv_ok = 1'b1;
    d = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      #1 d = {d[14:0], line};
      if (!mdio_oe) drv_ok = 1'b0;
    end
    @(negedge mdc);
    #1 rel_ok = !mdio_oe;
    idle(3);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bit all_zero;
    chk(mdio_oe == 1'b0, "R1 oe in reset", 32'(mdio_oe), 0);
    chk(rf_we == 1'b0, "R1 we in reset", 32'(rf_we), 0);
    all_zero = 1'b1;
    for (int a = 0; a < 32; a++) begin
      peek(5'(a), v);
      if (v != 16'h0) all_zero = 1'b0;
    end
    chk(all_zero, "R1 registers zero", 32'(all_zero), 1);
  endtask

  // rst release, then a start pattern whose 0 lands on the ignored edge
  task automatic t_skip_first();
    logic [15:0] v;
    int w0;
    w0 = we_cnt;
    @(negedge mdc);
    rst_n = 1'b1;
    m_oe  = 1'b0;
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    for (int i = 4; i >= 0; i--) bit_out(strap[i]);
    for (int i = 4; i >= 0; i--) bit_out(1'b0 ^ (i == 1 || i == 0));
    send_tail(2'b10, 16'hBEEF);
    idle(4);
    chk(we_cnt == w0, "R3 no write from first-cycle start", we_cnt - w0, 0);
    peek(5'd3, v);
    chk(v == 16'h0, "R3 reg3 untouched", v, 0);
    chk(mdio_oe == 1'b0, "R1 oe low after reset", 32'(mdio_oe), 0);
  endtask

  task automatic t_write_pre();
    logic [15:0] v;
    int w0;
    strap = 5'b11000;
    w0 = we_cnt;
    send_frame(32, 2'b01, 5'b00101, 5'd3, 16'hA5C3);
    chk(we_cnt == w0 + 1, "R5 one write strobe", we_cnt - w0, 1);
    chk(last_wa == 5'd3, "R5 write address", last_wa, 3);
    chk(last_wd == 16'hA5C3, "R5 write data", last_wd, 16'hA5C3);
    peek(5'd3, v);
    chk(v == 16'hA5C3, "R5 reg3 content", v, 16'hA5C3);
  endtask

  task automatic t_strap_late();
    logic [15:0] v;
    int w0;
    w0 = we_cnt;
    send_frame(2, 2'b01, 5'b11000, 5'd7, 16'h1234);
    chk(we_cnt == w0, "R2 late strap ignored", we_cnt - w0, 0);
    peek(5'd7, v);
    chk(v == 16'h0, "R2 reg7 untouched", v, 0);
  endtask

  task automatic t_no_preamble();
    logic [15:0] v;
    send_frame(0, 2'b01, 5'b00101, 5'd31, 16'h8001);
    peek(5'd31, v);
    chk(v == 16'h8001, "R4 write without preamble", v, 16'h8001);
  endtask

  task automatic t_reads();
    logic [15:0] d;
    bit t1, t2, dv, rl;
    mdio_read(1, 5'b00101, 5'd3, d, t1, t2, dv, rl);
    chk(t1, "R6 first turnaround released", 32'(t1), 1);
    chk(t2, "R6 second turnaround zero", 32'(t2), 1);
    chk(dv, "R6 driven through data", 32'(dv), 1);
    chk(d == 16'hA5C3, "R6 read reg3", d, 16'hA5C3);
    chk(rl, "R7 release after data", 32'(rl), 1);
    mdio_read(0, 5'b00101, 5'd31, d, t1, t2, dv, rl);
    chk(d == 16'h8001, "R6 read reg31 msb first", d, 16'h8001);
    chk(rl && t2, "R7 release on reg31 read", 32'(rl), 1);
    mdio_read(8, 5'b00101, 5'd0, d, t1, t2, dv, rl);
    chk(d == 16'h0000, "R6 read reg0", d, 0);
  endtask

  task automatic t_mismatch();
    logic [15:0] d, v;
    bit t1, t2, dv, rl;
    int o0, w0;
    o0 = oe_cnt;
    mdio_read(2, 5'b00100, 5'd3, d, t1, t2, dv, rl);
    chk(oe_cnt == o0, "R8 no drive for other address", oe_cnt - o0, 0);
    chk(d == 16'hFFFF, "R8 line stays high", d, 16'hFFFF);
    w0 = we_cnt;
    send_frame(2, 2'b01, 5'b00100, 5'd3, 16'hFFFF);
    chk(we_cnt == w0, "R8 no write for other address", we_cnt - w0, 0);
    peek(5'd3, v);
    chk(v == 16'hA5C3, "R8 reg3 kept", v, 16'hA5C3);
    send_frame(0, 2'b01, 5'b00101, 5'd3, 16'h0F0F);
    mdio_read(0, 5'b00101, 5'd3, d, t1, t2, dv, rl);
    chk(d == 16'h0F0F, "R8 next frame decoded", d, 16'h0F0F);
  endtask

  task automatic t_bad_op();
    logic [15:0] v;
    int o0, w0;
    o0 = oe_cnt;
    w0 = we_cnt;
    send_frame(1, 2'b11, 5'b00101, 5'd3, 16'hFFFF);
    send_frame(1, 2'b00, 5'b00101, 5'd3, 16'h0000);
    chk(we_cnt == w0, "R9 no write for opcode 00/11", we_cnt - w0, 0);
    chk(oe_cnt == o0, "R9 no drive for opcode 00/11", oe_cnt - o0, 0);
    peek(5'd3, v);
    chk(v == 16'h0F0F, "R9 reg3 kept", v, 16'h0F0F);
  endtask

  task automatic t_local_port();
    logic [15:0] v;
    peek(5'd31, v);
    chk(v == 16'h8001, "R10 local read reg31", v, 16'h8001);
    rf_addr = 5'd3;
    #1 v = rf_rdata;
    chk(v == 16'h0F0F, "R10 local read follows address", v, 16'h0F0F);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    we_cnt = 0;
    oe_cnt = 0;
    rst_n  = 1'b0;
    strap  = 5'b00101;
    m_oe   = 1'b0;
    m_val  = 1'b1;
    rf_addr = '0;
    repeat (3) @(negedge mdc);
    t_reset();
    t_skip_first();
    t_write_pre();
    t_strap_late();
    t_no_preamble();
    t_reads();
    t_mismatch();
    t_bad_op();
    t_local_port();
    report();
  end

  initial begin
    repeat (200000) @(posedge mdc);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule